// File: doc/BRIEF.md
# Tagged Translation Buffer with Write Protection

This block holds a small set of recent virtual-to-physical page translations so that most memory accesses avoid a page-table walk. Each lookup presents a virtual address, an access kind and the identifier of the running process. The block answers in the same cycle with a hit flag and the physical address. On a miss it raises a refill request, and on a store to a read-only page it raises a protection fault. A page walker outside the block answers the refill request by writing a new translation through the refill port. The faulting or missing access is then retried.

Every entry is tagged with a process identifier, so translations from several processes can be held at once and a context switch does not need a flush. A flush input still empties the buffer in one cycle. A per-entry reference bit records recent use. The replacement choice uses this bit, and a clear input resets all reference bits together. Entries are fully associative, the page offset passes through untouched, and the lookup path has no register on it.

Top module: `tlb_tagged`

## Requirements
- R1: Any of the `ENTRIES` (default 2) slots can hold any virtual page. Two different pages refilled one after the other both hit afterwards.
- R2: When a lookup hits, `lk_paddr` is the stored physical page number concatenated with the low 12 bits of `lk_vaddr` in the same cycle, and `lk_hit` is 1.
- R3: A valid lookup that matches no valid entry gives `lk_hit`=0, `lk_fault`=0, `lk_paddr`=0 and `refill_req`=1 in the same cycle.
- R4: A refill presented with `rf_valid`=1 is stored at the next rising clock edge. The same lookup then hits in the following cycle.
- R5: An entry matches only when both the virtual page number (`lk_vaddr[31:12]`) and `lk_asid` equal its stored values. The same page under another identifier misses.
- R6: `flush`=1 invalidates every entry at the next edge. If a refill is presented in the same cycle, the flush wins and the refill is dropped.
- R7: A hit sets the reference bit of the entry that hit. `ref_clear`=1 clears all reference bits at the next edge, and it wins over a hit in the same cycle. A newly refilled entry starts with its reference bit clear.
- R8: A refill goes to the lowest-numbered invalid entry. If all entries are valid, it goes to the lowest-numbered entry whose reference bit is clear. If every reference bit is set, it goes to entry 0.
- R9: Access kind encoding: 2'b00 read, 2'b01 write, 2'b10 fetch. A write that matches an entry marked read-only gives `lk_fault`=1, `lk_hit`=0, `lk_paddr`=0 and `refill_req`=0, and does not set the reference bit. Reads and fetches of a read-only entry hit, and so do writes to a writable entry.
- R10: With `lk_valid`=0, `lk_hit`, `lk_fault` and `refill_req` are all 0, `lk_paddr` is 0, and no reference bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the buffer |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| lk_asid | input | 8 | Identifier of the current process |
| lk_hit | output | 1 | Translation found and permitted |
| lk_paddr | output | 32 | Translated physical address, 0 when not a hit |
| lk_fault | output | 1 | Write to a read-only page |
| refill_req | output | 1 | Lookup missed; a walker should supply the translation |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Virtual page number to store |
| rf_ppn | input | 20 | Physical page number to store |
| rf_ro | input | 1 | Stored page is read-only |
| rf_asid | input | 8 | Process identifier to store with the page |
| flush | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
The bench builds the block with its default parameters: two entries, 20-bit page numbers, 8-bit identifiers and a 12-bit offset. With only two slots, a handful of refills is enough to fill the buffer. That reaches every branch of the victim choice: an invalid slot, exactly one unreferenced slot, and both slots referenced. It also reaches the cases where a flush or a reference clear lands in the same cycle as a refill or a hit. A behavioural model of the entry array predicts the hit, address, fault and request outputs for every cycle. Its predictions are compared with the outputs across identifier mismatches, read-only stores and eviction sequences.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_t;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ref_clear,
  input  logic              set_ref,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_ro,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              valid_q,
  output logic              ref_q,
  output logic              ro_q,
  output logic [PPN_W-1:0]  ppn_q,
  output logic              match
);
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;

  // Control bits: reset and flush empty the slot; a refill restarts it unreferenced
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= 1'b0;
      ref_q   <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      ref_q   <= 1'b0;
    end else if (ref_clear) begin
      ref_q   <= 1'b0;
    end else if (set_ref) begin
      ref_q   <= 1'b1;
    end
  end

  // Payload has no reset so it maps to plain fabric registers
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q  <= wr_vpn;
      asid_q <= wr_asid;
      ppn_q  <= wr_ppn;
      ro_q   <= wr_ro;
    end
  end

  assign match = valid_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);

  a_r6_flush_invalidates: assert property (@(posedge clk) disable iff (rst)
    flush |=> !valid_q);
  a_r4_refill_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> valid_q);
  a_r7_clear_refs: assert property (@(posedge clk) disable iff (rst)
    ref_clear |=> !ref_q);
  a_r7_ref_implies_valid: assert property (@(posedge clk) disable iff (rst)
    ref_q |-> valid_q);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 2,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_v,
  input  logic [ENTRIES-1:0] ref_v,
  output logic [IDX_W-1:0]   victim
);
  logic             found_inv, found_cold;
  logic [IDX_W-1:0] inv_idx, cold_idx;

  // Lowest invalid slot first, then lowest unreferenced slot, else slot 0
  always_comb begin
    found_inv  = 1'b0;
    found_cold = 1'b0;
    inv_idx    = '0;
    cold_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_v[i]) begin
        found_inv = 1'b1;
        inv_idx   = IDX_W'(i);
      end
      if (!ref_v[i]) begin
        found_cold = 1'b1;
        cold_idx   = IDX_W'(i);
      end
    end
    if (found_inv)       victim = inv_idx;
    else if (found_cold) victim = cold_idx;
    else                 victim = '0;
  end
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int OFF_W   = 12,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_kind,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_fault,
  output logic              refill_req,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic              rf_ro,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic              flush,
  input  logic              ref_clear
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0] valid_v, ref_v, ro_v, match_v, set_ref_v, wr_v;
  logic [PPN_W-1:0]   ppn_a [ENTRIES];
  logic [IDX_W-1:0]   victim, sel;
  logic               any_match, is_write;
  logic [VPN_W-1:0]   lk_vpn;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign is_write = (lk_kind == ACC_WRITE);

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_v (valid_v),
    .ref_v   (ref_v),
    .victim  (victim)
  );

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_v[g]      = rf_valid && !flush && (victim == IDX_W'(g));
      assign set_ref_v[g] = lk_hit && (sel == IDX_W'(g));
      tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_entry (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ref_clear (ref_clear),
        .set_ref   (set_ref_v[g]),
        .wr_en     (wr_v[g]),
        .wr_vpn    (rf_vpn),
        .wr_ppn    (rf_ppn),
        .wr_ro     (rf_ro),
        .wr_asid   (rf_asid),
        .lk_vpn    (lk_vpn),
        .lk_asid   (lk_asid),
        .valid_q   (valid_v[g]),
        .ref_q     (ref_v[g]),
        .ro_q      (ro_v[g]),
        .ppn_q     (ppn_a[g]),
        .match     (match_v[g])
      );
    end
  endgenerate

  // Lowest matching slot is the one used
  always_comb begin
    any_match = 1'b0;
    sel       = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_v[i]) begin
        any_match = 1'b1;
        sel       = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lk_fault   = lk_valid && any_match && ro_v[sel] && is_write;
    lk_hit     = lk_valid && any_match && !lk_fault;
    refill_req = lk_valid && !any_match;
    lk_paddr   = lk_hit ? {ppn_a[sel], lk_vaddr[OFF_W-1:0]} : '0;
  end

  a_r2_offset_passes: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  a_r3_miss_no_hit: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (!lk_hit && !lk_fault && lk_paddr == '0));
  a_r9_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (!lk_hit && !refill_req && lk_paddr == '0 && is_write));
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!lk_hit && !lk_fault));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_fault && !refill_req));
  a_r8_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_v));
endmodule

// File: tb/tlb_tagged_tb.sv
module tlb_tagged_tb;
  localparam int NE = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_fault, refill_req;
  logic [31:0] lk_paddr;
  logic        rf_valid, rf_ro, flush, ref_clear;
  logic [19:0] rf_vpn, rf_ppn;
  logic [7:0]  rf_asid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model of the entry array
  bit        m_v   [NE];
  bit        m_ref [NE];
  bit        m_ro  [NE];
  bit [19:0] m_vpn [NE];
  bit [19:0] m_ppn [NE];
  bit [7:0]  m_asid[NE];

  always #4 clk = ~clk;

  tlb_tagged u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_fault(lk_fault), .refill_req(refill_req),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_ro(rf_ro),
    .rf_asid(rf_asid), .flush(flush), .ref_clear(ref_clear)
  );

  function automatic int find_match(bit [19:0] vpn, bit [7:0] asid);
    for (int i = 0; i < NE; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    for (int i = 0; i < NE; i++) if (!m_v[i]) return i;
    for (int i = 0; i < NE; i++) if (!m_ref[i]) return i;
    return 0;
  endfunction

  task automatic compare(string tag);
    int    idx;
    bit    e_hit, e_fault, e_req;
    bit [31:0] e_pa;
    idx = find_match(lk_vaddr[31:12], lk_asid);
    e_fault = lk_valid && idx >= 0 && m_ro[idx] && lk_kind == 2'b01;
    e_hit   = lk_valid && idx >= 0 && !e_fault;
    e_req   = lk_valid && idx < 0;
    e_pa    = e_hit ? {m_ppn[idx], lk_vaddr[11:0]} : 32'h0;
    checks++;
    if (lk_hit !== e_hit || lk_fault !== e_fault || refill_req !== e_req || lk_paddr !== e_pa) begin
      fails++;
      $display("FAIL %s: got hit=%0b fault=%0b req=%0b pa=%h, expected hit=%0b fault=%0b req=%0b pa=%h",
               tag, lk_hit, lk_fault, refill_req, lk_paddr, e_hit, e_fault, e_req, e_pa);
    end
  endtask

  task automatic model_edge();
    int idx, vic;
    bit hit;
    idx = find_match(lk_vaddr[31:12], lk_asid);
    hit = lk_valid && idx >= 0 && !(m_ro[idx] && lk_kind == 2'b01);
    if (flush) begin
      for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_ref[i] = 0; end
    end else begin
      vic = pick_victim();
      if (hit) m_ref[idx] = 1;
      if (ref_clear) for (int i = 0; i < NE; i++) m_ref[i] = 0;
      if (rf_valid) begin
        m_v[vic] = 1; m_ref[vic] = 0; m_ro[vic] = rf_ro;
        m_vpn[vic] = rf_vpn; m_ppn[vic] = rf_ppn; m_asid[vic] = rf_asid;
      end
    end
  endtask

  // One cycle: drive at falling edge, check outputs, then advance the model at the rising edge
  task automatic cyc(string tag, bit lv, bit [31:0] va, bit [1:0] kind, bit [7:0] asid,
                     bit rv = 0, bit [19:0] rvpn = 0, bit [19:0] rppn = 0, bit rro = 0,
                     bit [7:0] rasid = 0, bit fl = 0, bit rc = 0);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_kind = kind; lk_asid = asid;
    rf_valid = rv; rf_vpn = rvpn; rf_ppn = rppn; rf_ro = rro; rf_asid = rasid;
    flush = fl; ref_clear = rc;
    #1 compare(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_ref[i] = 0; end
    rst = 1'b1; lk_valid = 0; lk_vaddr = 0; lk_kind = 0; lk_asid = 0;
    rf_valid = 0; rf_vpn = 0; rf_ppn = 0; rf_ro = 0; rf_asid = 0;
    flush = 0; ref_clear = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    cyc("R10 reset idle", 0, 32'h0, 2'b00, 8'd0);
    cyc("R3 cold miss", 1, 32'h0000_0123, 2'b00, 8'd1);
    cyc("R4 refill A", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00000, 20'h00011, 0, 8'd1);
    cyc("R4 R2 retry hits", 1, 32'h0000_0123, 2'b00, 8'd1);
    cyc("R5 other asid misses", 1, 32'h0000_0123, 2'b00, 8'd2);
    cyc("R8 refill B invalid slot", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00007, 20'h00022, 1, 8'd1);
    cyc("R1 B hits", 1, 32'h0000_7ffc, 2'b00, 8'd1);
    cyc("R1 A still hits", 1, 32'h0000_0abc, 2'b10, 8'd1);
    cyc("R9 fetch ro hits", 1, 32'h0000_7004, 2'b10, 8'd1);
    cyc("R9 write ro faults", 1, 32'h0000_7008, 2'b01, 8'd1);
    cyc("R9 write rw hits", 1, 32'h0000_0010, 2'b01, 8'd1);
    cyc("R7 clear refs with hit", 1, 32'h0000_0010, 2'b00, 8'd1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 touch B", 1, 32'h0000_7000, 2'b00, 8'd1);
    cyc("R8 refill C cold slot", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00002, 20'h00033, 0, 8'd1);
    cyc("R8 A evicted", 1, 32'h0000_0123, 2'b00, 8'd1);
    cyc("R8 C hits", 1, 32'h0000_2134, 2'b00, 8'd1);
    cyc("R8 B kept", 1, 32'h0000_7134, 2'b00, 8'd1);
    cyc("R8 refill D both hot", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00005, 20'h00044, 0, 8'd3);
    cyc("R8 C evicted", 1, 32'h0000_2134, 2'b00, 8'd1);
    cyc("R8 D hits", 1, 32'h0000_5555, 2'b01, 8'd3);
    cyc("R8 B kept again", 1, 32'h0000_7000, 2'b10, 8'd1);
    cyc("R7 clear refs", 0, 32'h0, 2'b00, 8'd0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 touch D", 1, 32'h0000_5000, 2'b00, 8'd3);
    cyc("R10 idle no ref set", 0, 32'h0000_7000, 2'b00, 8'd1);
    cyc("R8 refill E cold slot", 0, 32'h0, 2'b00, 8'd0, 1, 20'habcde, 20'h00055, 0, 8'd9);
    cyc("R7 B evicted", 1, 32'h0000_7000, 2'b00, 8'd1);
    cyc("R7 E hits", 1, 32'habcd_efff, 2'b00, 8'd9);
    cyc("R6 flush beats refill", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00066, 20'h00066, 0, 8'd4, 1);
    cyc("R6 D gone", 1, 32'h0000_5000, 2'b00, 8'd3);
    cyc("R6 E gone", 1, 32'habcd_e000, 2'b00, 8'd9);
    cyc("R6 dropped refill absent", 1, 32'h0006_6000, 2'b00, 8'd4);
    cyc("R8 refill after flush", 0, 32'h0, 2'b00, 8'd0, 1, 20'h00001, 20'h00077, 1, 8'd5);
    cyc("R4 new entry hits", 1, 32'h0000_1fff, 2'b00, 8'd5);
    cyc("R9 write faults again", 1, 32'h0000_1fff, 2'b01, 8'd5);
    cyc("R10 idle matching addr", 0, 32'h0000_1fff, 2'b00, 8'd5);
    cyc("R5 asid zero misses", 1, 32'h0000_1000, 2'b00, 8'd0);
    summary();
  end
endmodule